// File: doc/BRIEF.md
# Indexed Load/Store Address Unit

This block forms the memory address of a load or store from a base register value and a 12-bit unsigned immediate. A separate flag makes the immediate add to or subtract from the base. A two-bit mode selects one of four indexing schemes. They differ in two ways: whether the offset is applied before the access, and whether the base register receives an updated value. Memory is only ever reached through the base register; the block has no absolute addressing.

The address, the writeback enable, the writeback value, the alignment fault and the hazard flag are all combinational, and they are valid in the same cycle as the request. A small single-cycle memory stub sits behind the address path, so a complete load with base writeback can be observed. Load data returns one clock after the request, tagged with its destination register number.

The mode encoding is 0 for base only, 1 for pre-indexed, 2 for pre-indexed with writeback, and 3 for post-indexed.

Top module: `ldst_agu`

## Requirements
- R1: Mode 0 (base only): `addr_o` equals `base_i`, and `wb_en_o` is 0.
- R2: Mode 1 (pre-indexed): `addr_o` equals the offset sum, and `wb_en_o` is 0.
- R3: Mode 2 (pre-indexed with writeback): `addr_o` and `wb_data_o` both equal the offset sum, and `wb_en_o` is 1 when no fault or hazard applies.
- R4: Mode 3 (post-indexed): `addr_o` equals `base_i` unchanged, `wb_data_o` equals the offset sum, and `wb_en_o` is 1 when no fault or hazard applies.
- R5: The offset sum is `base_i + imm_i` when `sub_i`=0 and `base_i - imm_i` when `sub_i`=1. `imm_i` is zero-extended, and the result wraps modulo 2^32.
- R6: An access is a word access when `word_i`=1 and a byte access when `word_i`=0.
  - A word access with `addr_o[1:0]` not equal to 0 raises `fault_o`. The fault forces `wb_en_o` to 0, blocks the store, and yields no load result.
  - A byte access never faults.
- R7: A load (`store_i`=0) in mode 2 or 3 with `rd_i == rn_i` and no fault raises `hazard_o` and forces `wb_en_o` to 0, so the loaded data wins. The load result is still delivered.
- R8: `addr_o`, `wb_en_o`, `wb_data_o`, `fault_o` and `hazard_o` follow the inputs in the same cycle. `wb_en_o`, `fault_o` and `hazard_o` are 0 while `req_i`=0.
- R9: Load result timing:
  - A load accepted without fault gives `ld_valid_o`=1 after the next rising clock edge.
  - `ld_rd_o` then equals `rd_i`.
  - `ld_data_o` is the addressed word for a word load.
  - For a byte load, `ld_data_o` is byte lane `addr_o[1:0]` zero-extended.
  - Otherwise `ld_valid_o` is 0.
- R10: The memory holds 64 words indexed by `addr_o[7:2]`; higher address bits are ignored. A store without fault writes the whole word for a word access, or only lane `addr_o[1:0]` with `wdata_i[7:0]` for a byte access.
- R11: In reset, `ld_valid_o` is 0 and every memory word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| store_i | input | 1 | 1 store, 0 load |
| word_i | input | 1 | 1 word access, 0 byte access |
| mode_i | input | 2 | Indexing mode |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned immediate offset |
| sub_i | input | 1 | Subtract offset when 1 |
| rd_i | input | 4 | Load destination register |
| rn_i | input | 4 | Base register number |
| wdata_i | input | 32 | Store data |
| addr_o | output | 32 | Access address |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | 32 | Base writeback value |
| fault_o | output | 1 | Alignment fault |
| hazard_o | output | 1 | Destination equals base on writeback |
| ld_valid_o | output | 1 | Load result valid |
| ld_rd_o | output | 4 | Load result destination |
| ld_data_o | output | 32 | Load result data |

## Verification
The address, writeback, fault and hazard results are due in the request cycle itself. The bench drives each request on a falling edge and samples those results 1 ns later, before the next rising edge. Load results are due one rising edge later, so the bench samples them 1 ns after that edge. Directed cases cover subtract wraparound, the maximum immediate, the hazard case and misaligned stores; the random mix then exercises every mode against a bench memory model.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
  typedef enum logic [1:0] {
    IDX_BASE   = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_PRE_WB = 2'd2,
    IDX_POST   = 2'd3
  } idx_mode_e;
endpackage

// File: rtl/agu_offset_add.sv
module agu_offset_add #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] imm_i,
  input  logic          sub_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] imm_ext;
  assign imm_ext = {{(AW-OW){1'b0}}, imm_i};
  assign sum_o   = sub_i ? (base_i - imm_ext) : (base_i + imm_ext);
endmodule

// File: rtl/agu_mode_sel.sv
module agu_mode_sel
  import ldst_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          store_i,
  input  logic          word_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] sum_i,
  input  logic [RW-1:0] rd_i,
  input  logic [RW-1:0] rn_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_data_o,
  output logic          fault_o,
  output logic          hazard_o,
  output logic          acc_ok_o
);
  idx_mode_e mode;
  logic      pre_sel, wb_sel;

  assign mode    = idx_mode_e'(mode_i);
  assign pre_sel = (mode == IDX_PRE) || (mode == IDX_PRE_WB);
  assign wb_sel  = (mode == IDX_PRE_WB) || (mode == IDX_POST);

  assign addr_o    = pre_sel ? sum_i : base_i;
  assign wb_data_o = sum_i;
  assign fault_o   = req_i && word_i && (addr_o[1:0] != 2'b00);
  // load into the base register overrides the base update
  assign hazard_o  = req_i && !store_i && wb_sel && !fault_o && (rd_i == rn_i);
  assign wb_en_o   = req_i && wb_sel && !fault_o && !hazard_o;
  assign acc_ok_o  = req_i && !fault_o;

  assert_base_nowb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'd0) |-> (!wb_en_o && addr_o == base_i));
  assert_post_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'd3) |-> (addr_o == base_i));
  assert_fault_nowb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!wb_en_o && !acc_ok_o));
  assert_hazard_nowb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> (!wb_en_o && !store_i));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!wb_en_o && !fault_o && !hazard_o));
endmodule

// File: rtl/agu_mem_stub.sv
module agu_mem_stub #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int RW    = 4,
  parameter int WORDS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_ok_i,
  input  logic          store_i,
  input  logic          word_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] rd_i,
  output logic          ld_valid_o,
  output logic [RW-1:0] ld_rd_o,
  output logic [DW-1:0] ld_data_o
);
  localparam int IW = $clog2(WORDS);
  localparam int LW = $clog2(DW/8);

  logic [DW-1:0] mem_q [WORDS];
  logic [IW-1:0] idx;
  logic [LW-1:0] lane;
  logic [DW-1:0] rd_word;

  assign idx     = addr_i[LW +: IW];
  assign lane    = addr_i[LW-1:0];
  assign rd_word = mem_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (acc_ok_i && store_i) begin
      if (word_i) mem_q[idx] <= wdata_i;
      else        mem_q[idx][8*lane +: 8] <= wdata_i[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_rd_o    <= '0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= acc_ok_i && !store_i;
      if (acc_ok_i && !store_i) begin
        ld_rd_o   <= rd_i;
        ld_data_o <= word_i ? rd_word : {{(DW-8){1'b0}}, rd_word[8*lane +: 8]};
      end
    end
  end

  assert_ld_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_valid_o) |-> $past(acc_ok_i && !store_i));
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int OW        = 12,
  parameter int RW        = 4,
  parameter int MEM_WORDS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          store_i,
  input  logic          word_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] imm_i,
  input  logic          sub_i,
  input  logic [RW-1:0] rd_i,
  input  logic [RW-1:0] rn_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_data_o,
  output logic          fault_o,
  output logic          hazard_o,
  output logic          ld_valid_o,
  output logic [RW-1:0] ld_rd_o,
  output logic [DW-1:0] ld_data_o
);
  logic [AW-1:0] sum;
  logic          acc_ok;

  agu_offset_add #(.AW(AW), .OW(OW)) u_add (
    .base_i(base_i), .imm_i(imm_i), .sub_i(sub_i), .sum_o(sum)
  );

  agu_mode_sel #(.AW(AW), .RW(RW)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .store_i(store_i),
    .word_i(word_i), .mode_i(mode_i), .base_i(base_i), .sum_i(sum),
    .rd_i(rd_i), .rn_i(rn_i), .addr_o(addr_o), .wb_en_o(wb_en_o),
    .wb_data_o(wb_data_o), .fault_o(fault_o), .hazard_o(hazard_o),
    .acc_ok_o(acc_ok)
  );

  agu_mem_stub #(.AW(AW), .DW(DW), .RW(RW), .WORDS(MEM_WORDS)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_ok_i(acc_ok), .store_i(store_i),
    .word_i(word_i), .addr_i(addr_o), .wdata_i(wdata_i), .rd_i(rd_i),
    .ld_valid_o(ld_valid_o), .ld_rd_o(ld_rd_o), .ld_data_o(ld_data_o)
  );
endmodule

// File: tb/ldst_agu_tb_top.sv
module ldst_agu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, store_i = 1'b0, word_i = 1'b1, sub_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] base_i = '0, wdata_i = '0;
  logic [11:0] imm_i = '0;
  logic [3:0]  rd_i = '0, rn_i = '0;
  logic [31:0] addr_o, wb_data_o, ld_data_o;
  logic        wb_en_o, fault_o, hazard_o, ld_valid_o;
  logic [3:0]  ld_rd_o;

  int checks = 0, failures = 0;
  logic [31:0] model [64];

  ldst_agu dut_i (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_sum(logic [31:0] b, logic [11:0] im, logic s);
    return s ? b - {20'd0, im} : b + {20'd0, im};
  endfunction

  task automatic op(input logic st, input logic wd, input logic [1:0] md,
                    input logic [31:0] b, input logic [11:0] im, input logic s,
                    input logic [3:0] rd, input logic [3:0] rn, input logic [31:0] wdat);
    logic [31:0] sm, ea, ew, ld_exp;
    logic        flt, hz, wbsel, eld;
    @(negedge clk_i);
    req_i = 1; store_i = st; word_i = wd; mode_i = md; base_i = b;
    imm_i = im; sub_i = s; rd_i = rd; rn_i = rn; wdata_i = wdat;
    sm    = f_sum(b, im, s);
    ea    = (md == 2'd1 || md == 2'd2) ? sm : b;
    wbsel = (md == 2'd2 || md == 2'd3);
    flt   = wd && (ea[1:0] != 2'b00);
    hz    = !st && wbsel && !flt && (rd == rn);
    ew    = ea;
    #1;
    chk($sformatf("R5/R1-R4 addr mode%0d", md), addr_o, ew);
    chk("R6 fault", {31'd0, fault_o}, {31'd0, flt});
    chk("R7 hazard", {31'd0, hazard_o}, {31'd0, hz});
    chk("R3/R4 wb_en", {31'd0, wb_en_o}, {31'd0, wbsel && !flt && !hz});
    if (wbsel) chk("R3/R4 wb_data", wb_data_o, sm);
    eld = !st && !flt;
    if (word_i) ld_exp = model[ea[7:2]];
    else        ld_exp = {24'd0, model[ea[7:2]][8*ea[1:0] +: 8]};
    if (st && !flt) begin
      if (wd) model[ea[7:2]] = wdat;
      else    model[ea[7:2]][8*ea[1:0] +: 8] = wdat[7:0];
    end
    @(posedge clk_i); #1;
    req_i = 0;
    chk("R9 ld_valid", {31'd0, ld_valid_o}, {31'd0, eld});
    if (eld) begin
      chk("R9 ld_rd", {28'd0, ld_rd_o}, {28'd0, rd});
      chk("R9/R10 ld_data", ld_data_o, ld_exp);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) model[i] = '0;
    #5;
    chk("R11 ld_valid in reset", {31'd0, ld_valid_o}, 32'd0);
    rst_ni = 1;
    // R11 memory cleared
    op(0, 1, 2'd0, 32'h0000_0040, 12'd0, 0, 4'd1, 4'd2, 0);
    // R8 idle outputs quiet
    @(negedge clk_i); #1;
    chk("R8 idle wb_en", {31'd0, wb_en_o}, 32'd0);
    chk("R8 idle fault", {31'd0, fault_o}, 32'd0);
    // R5 subtract wraparound, R3 writeback
    op(1, 1, 2'd2, 32'h0000_0004, 12'd8, 1, 4'd1, 4'd2, 32'hDEAD_BEEF);
    // R5 max immediate, R2
    op(0, 1, 2'd1, 32'h0000_0001, 12'hFFF, 0, 4'd3, 4'd4, 0);
    // R4 post-indexed load of stored word
    op(0, 1, 2'd3, 32'hFFFF_FFFC, 12'd4, 0, 4'd5, 4'd6, 0);
    // R7 hazard
    op(0, 1, 2'd3, 32'h0000_0010, 12'd4, 0, 4'd7, 4'd7, 0);
    // R6 misaligned word store blocked, then check memory
    op(1, 1, 2'd2, 32'h0000_0020, 12'd2, 0, 4'd0, 4'd1, 32'h1111_1111);
    op(0, 1, 2'd0, 32'h0000_0020, 12'd0, 0, 4'd2, 4'd1, 0);
    op(0, 1, 2'd0, 32'h0000_0024, 12'd0, 0, 4'd2, 4'd1, 0);
    // R10 byte store lane 2, byte load, R6 byte never faults
    op(1, 0, 2'd1, 32'h0000_0030, 12'd2, 0, 4'd0, 4'd1, 32'h0000_00A5);
    op(0, 0, 2'd1, 32'h0000_0030, 12'd2, 0, 4'd9, 4'd1, 0);
    op(0, 1, 2'd0, 32'h0000_0030, 12'd0, 0, 4'd9, 4'd1, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] b;
      b = $urandom();
      if ($urandom_range(3) != 0) b = {24'd0, b[7:2], ($urandom_range(3) == 0) ? b[1:0] : 2'b00};
      op($urandom_range(1), $urandom_range(3) != 0, 2'($urandom_range(3)), b,
         ($urandom_range(3) == 0) ? 12'($urandom()) : {6'd0, 4'($urandom()), 2'b00},
         $urandom_range(1), 4'($urandom()), 4'($urandom_range(3)), $urandom());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule